// File: doc/BRIEF.md
# Transparent Serial Link Byte Receiver

This block takes a serial bit stream, one bit per cycle in which a valid strobe is high, and turns it into bytes for a host without any frame processing: flags, stuffed bits and check sequences pass through as ordinary data. Byte alignment comes from one of two sources. In hunt mode the block compares the most recent eight bits with a programmable alignment character on every valid bit. The first window that equals the character fixes the byte boundary, and that window becomes the first byte stored. In free-run mode the first valid bit after a restart becomes bit 0 of the first byte.

Completed bytes go into a byte-wide FIFO that the host empties through a show-ahead pop port. A programmable threshold drives a fill indicator, and a sticky flag records bytes that were lost because the FIFO was full. A lock indicator tells the host when alignment has been established.

Top module: `tlink_rx`

## Requirements
- R1: After reset, `match_stat`, `ovr_flag`, `rd_valid` and `fifo_level` are all 0.
- R2: In hunt mode (`hunt_en`=1), no byte enters the FIFO while `match_stat` is 0.
- R3: In hunt mode, on each valid bit the block compares the window made of that bit and the seven previous valid bits with the alignment character, whatever the bit offset. On a match, `match_stat` goes to 1 and the matching byte is the first FIFO entry.
- R4: Once locked, every further group of 8 valid bits forms one byte. The first bit received is bit 0 of the byte, so the stream is taken LSB first.
- R5: In free-run mode (`hunt_en`=0), `match_stat` goes to 1 on the first valid bit, and that bit is bit 0 of the first stored byte.
- R6: While `xparent_en` is 0, valid bits are ignored: `fifo_level` does not rise and `match_stat` stays 0.
- R7: Clearing `xparent_en`, or changing `hunt_en`, clears `match_stat` and restarts alignment. Bits that arrive afterwards are not stored until alignment is found again.
- R8: When `fill_lvl` is N (1 to 63), `fill_flag` equals (`fifo_level` >= N). The flag follows the current level, so it falls as bytes are popped.
- R9: When `fill_lvl` is 0, `fill_flag` is 1 only when the FIFO holds all 64 bytes.
- R10: A byte that completes while the FIFO is full is discarded, and `ovr_flag` is set. The flag stays set until a one-cycle `ovr_ack` pulse clears it.
- R11: The alignment character is 0x7E after reset. A one-cycle `char_wr` pulse loads `char_wdata` as the new character.
- R12: `rd_data` shows the oldest byte while `rd_valid` is 1. A pop while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Marks `bit_in` as a valid bit this cycle |
| xparent_en | input | 1 | Enables transparent reception |
| hunt_en | input | 1 | 1: hunt for the alignment character; 0: free-run |
| char_wr | input | 1 | Loads `char_wdata` into the alignment character |
| char_wdata | input | 8 | New alignment character |
| fill_lvl | input | 6 | Fill threshold; 0 means completely full |
| pop | input | 1 | Removes the oldest byte |
| ovr_ack | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Oldest byte in the FIFO |
| rd_valid | output | 1 | The FIFO is not empty |
| fifo_level | output | 7 | Number of bytes held |
| fill_flag | output | 1 | Threshold status |
| match_stat | output | 1 | Alignment established |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The bound checker enforces several rules on every cycle. The threshold rules for both the zero and the non-zero setting must hold. The level must never pass the depth, and an overrun flag may only rise from a full FIFO. Nothing may be stored while unlocked or disabled, and lock must drop after transparent mode is cleared. Other behaviour only shows in the bench's scenarios: that alignment is found at every one of the eight bit offsets, the LSB-first byte values, the reset character, the free-run start bit, and that the discarded byte really is missing from the drained data.

// File: rtl/tlink_pkg.sv
// Shared constants for the transparent link receiver.
package tlink_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] CHAR_RST = 8'h7E;
endpackage

// File: rtl/tlink_hunt.sv
// Bit aligner: shifts valid bits in LSB first and either hunts for the
// alignment character (sliding window) or locks on the first bit.
// It emits one byte per 8 locked bits.
// Assumes: bit_vld is high at most once per clock; config may change at any time.
module tlink_hunt #(
    parameter int BYTE_W = tlink_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              xparent_en,
    input  logic              hunt_en,
    input  logic [BYTE_W-1:0] match_char,
    output logic              locked,
    output logic              push,
    output logic [BYTE_W-1:0] push_data
);
    localparam int BC_W   = $clog2(BYTE_W);
    localparam int SEEN_W = BC_W + 1;

    logic [BYTE_W-1:0] sr;
    logic [BYTE_W-1:0] window;
    logic [SEEN_W-1:0] seen;
    logic [BC_W-1:0]   bitcnt;
    logic              hunt_q;
    logic              restart;
    logic              hit;
    logic              byte_done;

    // Window decode: candidate byte, restart and completion conditions.
    always_comb begin
        window    = {bit_in, sr[BYTE_W-1:1]};
        restart   = !xparent_en || (hunt_en != hunt_q);
        hit       = hunt_en && (seen >= SEEN_W'(BYTE_W-1)) && (window == match_char);
        byte_done = (bitcnt == BC_W'(BYTE_W-1));
        push      = bit_vld && !restart && (locked ? byte_done : hit);
        push_data = window;
    end

    // Alignment state: shift register, warm-up count, bit position, lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr     <= '0;
            seen   <= '0;
            bitcnt <= '0;
            locked <= 1'b0;
            hunt_q <= 1'b1;
        end else begin
            hunt_q <= hunt_en;
            if (restart) begin
                seen   <= '0;
                bitcnt <= '0;
                locked <= 1'b0;
            end else if (bit_vld) begin
                sr <= window;
                if (locked) begin
                    bitcnt <= byte_done ? '0 : bitcnt + BC_W'(1);
                end else if (!hunt_en) begin
                    locked <= 1'b1;
                    bitcnt <= BC_W'(1);
                end else if (hit) begin
                    locked <= 1'b1;
                    bitcnt <= '0;
                end else if (seen < SEEN_W'(BYTE_W-1)) begin
                    seen <= seen + SEEN_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/tlink_fifo.sv
// Byte FIFO with show-ahead read, an occupancy count and a sticky overrun flag.
// Assumes: DEPTH is a power of two. A push while full is dropped and recorded.
module tlink_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    input  logic             ovr_ack,
    output logic [W-1:0]     rd_data,
    output logic             rd_valid,
    output logic [CNT_W-1:0] level,
    output logic             ovr
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic             full;
    logic             do_push;
    logic             do_pop;

    // Qualified push and pop.
    always_comb begin
        full     = (level == CNT_W'(DEPTH));
        do_push  = push && !full;
        do_pop   = pop && (level != '0);
        rd_valid = (level != '0);
        rd_data  = mem[rptr];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Pointers, occupancy and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
            ovr   <= 1'b0;
        end else begin
            if (do_push) wptr <= wptr + PTR_W'(1);
            if (do_pop)  rptr <= rptr + PTR_W'(1);
            case ({do_push, do_pop})
                2'b10:   level <= level + CNT_W'(1);
                2'b01:   level <= level - CNT_W'(1);
                default: level <= level;
            endcase
            if (push && full) ovr <= 1'b1;
            else if (ovr_ack) ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/tlink_fill.sv
// Threshold compare: zero selects "completely full", otherwise level >= threshold.
// Assumes: the threshold range is below DEPTH.
module tlink_fill #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 6,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0] level,
    input  logic [LVL_W-1:0] fill_lvl,
    output logic             fill_flag
);
    // Threshold decision taken from the current level.
    always_comb begin
        if (fill_lvl == '0) fill_flag = (level == CNT_W'(DEPTH));
        else                fill_flag = (level >= CNT_W'(fill_lvl));
    end
endmodule

// File: rtl/tlink_rx.sv
// Transparent serial link byte receiver top. It holds the alignment
// character register and joins the aligner, the FIFO and the threshold logic.
// Assumes: a synchronous active-low reset and single-cycle control pulses.
module tlink_rx #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 6,
    localparam int CNT_W = $clog2(DEPTH) + 1,
    localparam int BW    = tlink_pkg::BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_vld,
    input  logic             xparent_en,
    input  logic             hunt_en,
    input  logic             char_wr,
    input  logic [BW-1:0]    char_wdata,
    input  logic [LVL_W-1:0] fill_lvl,
    input  logic             pop,
    input  logic             ovr_ack,
    output logic [BW-1:0]    rd_data,
    output logic             rd_valid,
    output logic [CNT_W-1:0] fifo_level,
    output logic             fill_flag,
    output logic             match_stat,
    output logic             ovr_flag
);
    logic [BW-1:0] char_q;
    logic          push;
    logic [BW-1:0] push_data;

    // Alignment character register.
    always_ff @(posedge clk) begin
        if (!rst_n)       char_q <= tlink_pkg::CHAR_RST;
        else if (char_wr) char_q <= char_wdata;
    end

    tlink_hunt #(.BYTE_W(BW)) hunt_i (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .xparent_en(xparent_en), .hunt_en(hunt_en), .match_char(char_q),
        .locked(match_stat), .push(push), .push_data(push_data)
    );

    tlink_fifo #(.DEPTH(DEPTH), .W(BW)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .ovr_ack(ovr_ack), .rd_data(rd_data), .rd_valid(rd_valid),
        .level(fifo_level), .ovr(ovr_flag)
    );

    tlink_fill #(.DEPTH(DEPTH), .LVL_W(LVL_W)) fill_i (
        .level(fifo_level), .fill_lvl(fill_lvl), .fill_flag(fill_flag)
    );
endmodule

// File: rtl/tlink_rx_chk.sv
// Property checker for tlink_rx, attached to it by bind.
module tlink_rx_chk #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 6,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xparent_en,
    input logic [LVL_W-1:0] fill_lvl,
    input logic [CNT_W-1:0] fifo_level,
    input logic             fill_flag,
    input logic             match_stat,
    input logic             ovr_flag,
    input logic             rd_valid
);
    p_no_store_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !match_stat |=> (match_stat || fifo_level <= $past(fifo_level)));

    p_ignore_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !xparent_en |=> (fifo_level <= $past(fifo_level)));

    p_lock_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !xparent_en |=> !match_stat);

    p_fill_thresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_lvl != '0) |-> (fill_flag == (fifo_level >= CNT_W'(fill_lvl))));

    p_fill_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_lvl == '0) |-> (fill_flag == (fifo_level == CNT_W'(DEPTH))));

    p_ovr_from_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> ($past(fifo_level) == CNT_W'(DEPTH)));

    p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= CNT_W'(DEPTH));

    p_empty_invalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == '0) |-> !rd_valid);
endmodule

bind tlink_rx tlink_rx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .xparent_en(xparent_en), .fill_lvl(fill_lvl),
    .fifo_level(fifo_level), .fill_flag(fill_flag), .match_stat(match_stat),
    .ovr_flag(ovr_flag), .rd_valid(rd_valid)
);

// File: tb/tlink_rx_tb_top.sv
// Self-checking bench for tlink_rx: offset sweep, threshold sweep, overrun.
module tlink_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0, bit_vld = 1'b0;
    logic       xparent_en = 1'b1, hunt_en = 1'b1;
    logic       char_wr = 1'b0;
    logic [7:0] char_wdata = 8'h00;
    logic [5:0] fill_lvl = 6'd0;
    logic       pop = 1'b0, ovr_ack = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid, fill_flag, match_stat, ovr_flag;
    logic [6:0] fifo_level;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tlink_rx dut_i (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .xparent_en(xparent_en), .hunt_en(hunt_en), .char_wr(char_wr),
        .char_wdata(char_wdata), .fill_lvl(fill_lvl), .pop(pop), .ovr_ack(ovr_ack),
        .rd_data(rd_data), .rd_valid(rd_valid), .fifo_level(fifo_level),
        .fill_flag(fill_flag), .match_stat(match_stat), .ovr_flag(ovr_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_tb();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_in = b; bit_vld = 1'b1;
        @(negedge clk); bit_vld = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic pop_chk(input string req, input int exp);
        @(negedge clk);
        check({req, " rd_valid"}, int'(rd_valid), 1);
        check({req, " data"}, int'(rd_data), exp);
        pop = 1'b1;
        @(negedge clk); pop = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (fifo_level != 0) begin
            pop = 1'b1; @(negedge clk);
        end
        pop = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk); xparent_en = 1'b0;
        @(negedge clk); xparent_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_tb();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 match_stat", int'(match_stat), 0);
        check("R1 level", int'(fifo_level), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 ovr_flag", int'(ovr_flag), 0);

        // R12: pop on empty has no effect
        @(negedge clk); pop = 1'b1; @(negedge clk); pop = 1'b0;
        check("R12 empty pop level", int'(fifo_level), 0);

        // R11: default character 0x7E found after a zero prefix
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        send_byte(8'h7E);
        check("R11 default lock", int'(match_stat), 1);
        check("R11 level", int'(fifo_level), 1);
        pop_chk("R11 first byte", 8'h7E);
        restart();

        // R11: program a new character
        @(negedge clk); char_wr = 1'b1; char_wdata = 8'hA5;
        @(negedge clk); char_wr = 1'b0;

        // R3/R2/R4: sweep every bit offset of a zero prefix
        for (int off = 0; off < 8; off++) begin
            restart();
            for (int i = 0; i < off; i++) send_bit(1'b0);
            for (int i = 0; i < 7; i++) send_bit(((8'hA5 >> i) & 1) != 0);
            check("R2 no store before match", int'(fifo_level), 0);
            check("R2 unlocked before match", int'(match_stat), 0);
            send_bit(1'b1);
            check("R3 locked at match", int'(match_stat), 1);
            for (int k = 0; k < 3; k++) send_byte(8'((off * 37 + k * 11 + 3) & 8'hFF));
            check("R4 level", int'(fifo_level), 4);
            pop_chk("R3 match byte first", 8'hA5);
            for (int k = 0; k < 3; k++) pop_chk("R4 lsb-first byte", (off * 37 + k * 11 + 3) & 8'hFF);
        end

        // R7: changing hunt_en and clearing xparent_en drop lock
        restart();
        send_byte(8'hA5);
        check("R7 locked", int'(match_stat), 1);
        @(negedge clk); hunt_en = 1'b0;
        @(negedge clk); hunt_en = 1'b1;
        @(negedge clk);
        check("R7 lock cleared by mode change", int'(match_stat), 0);
        send_byte(8'h00);
        check("R7 no store after restart", int'(fifo_level), 1);
        send_byte(8'hA5);
        check("R7 relock", int'(match_stat), 1);
        @(negedge clk); xparent_en = 1'b0;
        @(negedge clk);
        check("R7 lock cleared by disable", int'(match_stat), 0);

        // R6: bits ignored while disabled
        for (int i = 0; i < 16; i++) send_bit(i[0]);
        check("R6 level unchanged", int'(fifo_level), 2);
        check("R6 still unlocked", int'(match_stat), 0);
        xparent_en = 1'b1;
        drain();

        // R5: free-run starts on the first bit
        @(negedge clk); hunt_en = 1'b0;
        restart();
        send_bit(1'b0);
        check("R5 lock on first bit", int'(match_stat), 1);
        for (int i = 1; i < 8; i++) send_bit(((8'h3C >> i) & 1) != 0);
        send_byte(8'h81);
        pop_chk("R5 first byte", 8'h3C);
        pop_chk("R5 second byte", 8'h81);

        // R10: fill to full, then one extra byte overruns
        restart();
        for (int k = 0; k < 64; k++) send_byte(8'(k));
        check("R10 full level", int'(fifo_level), 64);
        check("R10 no early ovr", int'(ovr_flag), 0);
        send_byte(8'hEE);
        check("R10 level after overrun", int'(fifo_level), 64);
        check("R10 ovr set", int'(ovr_flag), 1);
        repeat (3) @(negedge clk);
        check("R10 ovr sticky", int'(ovr_flag), 1);
        ovr_ack = 1'b1; @(negedge clk); ovr_ack = 1'b0;
        check("R10 ovr cleared", int'(ovr_flag), 0);

        // R8/R9: every threshold at every level while draining
        for (int lvl = 64; lvl >= 0; lvl--) begin
            for (int f = 0; f < 64; f++) begin
                fill_lvl = 6'(f);
                #1;
                if (f == 0) check("R9 full-only flag", int'(fill_flag), (lvl == 64) ? 1 : 0);
                else        check("R8 threshold flag", int'(fill_flag), (lvl >= f) ? 1 : 0);
            end
            @(negedge clk);
            check("R8 level tracks pops", int'(fifo_level), lvl);
            if (lvl > 0) pop_chk("R10 kept data", 64 - lvl);
        end
        check("R10 extra byte discarded", int'(rd_valid), 0);

        finish_tb();
    end
endmodule